// File: doc/BRIEF.md
# Atomic 16-bit register bridge

This block places a set of 16-bit peripheral registers behind an 8-bit register bus so that software can move a whole 16-bit value in two byte accesses and still see, or commit, all sixteen bits as of one clock cycle. A single shared holding byte carries the half that is not on the bus at the moment. A low-byte write parks its data in the holding byte. The matching high-byte write then commits both halves together. A low-byte read returns the live low byte and, in the same edge, freezes the live high byte into the holding byte. The matching high-byte read then returns that frozen half.

On the peripheral side, each 16-bit register can be loaded by hardware in any cycle, for example from a free-running counter. The register's value and a one-cycle commit pulse are presented to the peripheral. The holding byte has its own bus address, so an interrupt handler can save it and put it back. The bus also reaches a plain 8-bit scratch byte that is used for testing.

Top module: `atomic_bridge16`

## Requirements
- R1: A synchronous active-high reset clears the holding byte, the scratch byte, every 16-bit register, the read data and every commit pulse to zero.
- R2: A bus write to the low-byte address of register k (address 2+2k) stores the data only in the holding byte. Register k keeps its value and its commit pulse stays low.
- R3: A bus write to the high-byte address of register k (address 3+2k) loads {write data, holding byte} into register k at one clock edge. It raises the register's commit pulse for exactly the following cycle.
- R4: A bus read of the low-byte address of register k returns bits 7:0 of register k. At the same edge it copies bits 15:8 into the holding byte.
- R5: A bus read of the high-byte address of register k returns the holding byte, not the register's live upper byte.
- R6: The holding byte is readable and writable at address 0. The scratch byte is readable and writable at address 1.
- R7: The holding byte is shared by all 16-bit registers. A low-byte access to a different register placed between the two halves of a pair replaces the half carried over to the later high-byte access.
- R8: When the read strobe and the write strobe are both high in the same cycle, only the write takes effect. The read data keeps its previous value.
- R9: Read data is registered. It changes at the clock edge that samples the read strobe and is valid in the cycle after it.
- R10: A high-byte bus write in the same cycle as a hardware load of the same register wins over the hardware value.
- R11: A hardware load strobe for register k copies the hardware input into register k at the next edge. Across a low-then-high read pair, the two returned bytes always form one value the register held at a single edge, even when the register changes every cycle.
- R12: A read of an address that maps to nothing returns 0x00. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address on the register bus |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| hw_we | input | N_REGS | Hardware load strobe, one bit per 16-bit register |
| hw_data | input | 16*N_REGS | Hardware load values, register k in bits 16k+15:16k |
| reg_q | output | 16*N_REGS | Current value of every 16-bit register |
| reg_load | output | N_REGS | One-cycle pulse after a bus commit to that register |

## Verification
A stale or wrongly captured holding byte is not visible when it happens. It shows up only at the second half of a byte pair: as a wrong high byte on bus_rdata one cycle after the high-byte read strobe, or as a wrong low half in reg_q one cycle after the high-byte write. A commit that skips the holding byte, or that lands in two steps, shows in reg_q and reg_load at the edge that follows the high-byte write. Tearing against a register that changes every cycle shows as a read pair that matches no single value sampled from reg_q, and it is caught on the first pair that crosses a carry into the upper byte.

// File: rtl/bridge16_pkg.sv
package bridge16_pkg;

  // Fixed byte addresses of the bridge; 16-bit registers follow from 2 upward.
  localparam int unsigned HOLD_ADDR = 0;
  localparam int unsigned SCR_ADDR  = 1;
  localparam int unsigned PAIR_BASE = 2;

  // Source of the next registered read byte.
  typedef enum logic [2:0] {
    RS_HOLD_OUT = 3'd0,  // no read this cycle: keep last byte
    RS_TEMP     = 3'd1,
    RS_SCR      = 3'd2,
    RS_LO       = 3'd3,
    RS_HI       = 3'd4,
    RS_ZERO     = 3'd5
  } rd_src_e;

  function automatic int unsigned lo_addr(input int unsigned k);
    return PAIR_BASE + 2 * k;
  endfunction

  function automatic int unsigned hi_addr(input int unsigned k);
    return PAIR_BASE + 2 * k + 1;
  endfunction

endpackage

// File: rtl/bridge16_decode.sv
module bridge16_decode
  import bridge16_pkg::*;
#(
  parameter int N_REGS = 2,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_tmp,
  output logic              wr_scr,
  output logic [N_REGS-1:0] wr_lo,
  output logic [N_REGS-1:0] wr_hi,
  output logic [N_REGS-1:0] rd_lo,
  output rd_src_e           rd_src,
  output logic [IDX_W-1:0]  rd_idx
);

  logic              rd_go;
  logic [N_REGS-1:0] lo_hit;
  logic [N_REGS-1:0] hi_hit;

  // a write in the same cycle masks the read entirely
  assign rd_go = rd & ~wr;

  for (genvar k = 0; k < N_REGS; k++) begin : g_hit
    assign lo_hit[k] = (addr == ADDR_W'(lo_addr(k)));
    assign hi_hit[k] = (addr == ADDR_W'(hi_addr(k)));
    assign wr_lo[k]  = wr & lo_hit[k];
    assign wr_hi[k]  = wr & hi_hit[k];
    assign rd_lo[k]  = rd_go & lo_hit[k];
  end

  assign wr_tmp = wr & (addr == ADDR_W'(HOLD_ADDR));
  assign wr_scr = wr & (addr == ADDR_W'(SCR_ADDR));

  always_comb begin
    rd_idx = '0;
    for (int k = 0; k < N_REGS; k++) begin
      if (lo_hit[k] || hi_hit[k]) rd_idx = IDX_W'(k);
    end
  end

  always_comb begin
    if (!rd_go)                              rd_src = RS_HOLD_OUT;
    else if (addr == ADDR_W'(HOLD_ADDR))     rd_src = RS_TEMP;
    else if (addr == ADDR_W'(SCR_ADDR))      rd_src = RS_SCR;
    else if (|lo_hit)                        rd_src = RS_LO;
    else if (|hi_hit)                        rd_src = RS_HI;
    else                                     rd_src = RS_ZERO;
  end

  // R8
  wr_masks_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && rd) |-> (rd_src == RS_HOLD_OUT && rd_lo == '0));

endmodule

// File: rtl/bridge16_temp.sv
module bridge16_temp (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_bus,
  input  logic [7:0] bus_d,
  input  logic       ld_cap,
  input  logic [7:0] cap_d,
  output logic [7:0] q
);

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (ld_bus) q <= bus_d;
    else if (ld_cap) q <= cap_d;
  end

  // R4
  hi_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_cap && !ld_bus) |=> (q == $past(cap_d)));

  // R6
  hold_write_chk: assert property (@(posedge clk) disable iff (rst)
    ld_bus |=> (q == $past(bus_d)));

endmodule

// File: rtl/bridge16_reg.sv
module bridge16_reg #(
  parameter int DW = 16,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_we,
  input  logic [DW-1:0] hw_d,
  input  logic          commit,
  input  logic [HW-1:0] hi_d,
  input  logic [HW-1:0] lo_d,
  output logic [DW-1:0] q,
  output logic          load
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      load <= 1'b0;
    end else begin
      load <= commit;
      if (commit)     q <= {hi_d, lo_d};
      else if (hw_we) q <= hw_d;
    end
  end

  // R3
  pair_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (q == {$past(hi_d), $past(lo_d)}) && load);

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !load || $past(commit));

  // R11
  hw_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_we && !commit) |=> (q == $past(hw_d)));

endmodule

// File: rtl/bridge16_rdmux.sv
module bridge16_rdmux
  import bridge16_pkg::*;
#(
  parameter int N_REGS = 2,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rd_src_e              src,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           tmp,
  input  logic [7:0]           scr,
  input  logic [16*N_REGS-1:0] regs,
  output logic [7:0]           rdata
);

  logic [7:0] lo_sel;

  assign lo_sel = regs[int'(idx)*16 +: 8];

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (src)
        RS_TEMP:     rdata <= tmp;
        RS_SCR:      rdata <= scr;
        RS_LO:       rdata <= lo_sel;
        RS_HI:       rdata <= tmp;
        RS_ZERO:     rdata <= '0;
        default:     rdata <= rdata;
      endcase
    end
  end

  // R5
  hi_from_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (src == RS_HI) |=> (rdata == $past(tmp)));

  // R8
  rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (src == RS_HOLD_OUT) |=> $stable(rdata));

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (src == RS_ZERO) |=> (rdata == 8'h00));

endmodule

// File: rtl/atomic_bridge16.sv
module atomic_bridge16
  import bridge16_pkg::*;
#(
  parameter int N_REGS = 2,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1,
  localparam int DW    = 16 * N_REGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [N_REGS-1:0] hw_we,
  input  logic [DW-1:0]     hw_data,
  output logic [DW-1:0]     reg_q,
  output logic [N_REGS-1:0] reg_load
);

  initial begin
    if (2 ** ADDR_W < PAIR_BASE + 2 * N_REGS)
      $error("ADDR_W too small for N_REGS pairs");
  end

  logic              wr_tmp, wr_scr;
  logic [N_REGS-1:0] wr_lo, wr_hi, rd_lo;
  rd_src_e           rd_src;
  logic [IDX_W-1:0]  rd_idx;
  logic [7:0]        hold_q;
  logic [7:0]        scr_q;
  logic [7:0]        cap_byte;

  bridge16_decode #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_tmp (wr_tmp),
    .wr_scr (wr_scr),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .rd_lo  (rd_lo),
    .rd_src (rd_src),
    .rd_idx (rd_idx)
  );

  // upper byte of the register whose low half is being read
  assign cap_byte = reg_q[int'(rd_idx)*16 + 8 +: 8];

  bridge16_temp u_hold (
    .clk    (clk),
    .rst    (rst),
    .ld_bus (wr_tmp | (|wr_lo)),
    .bus_d  (bus_wdata),
    .ld_cap (|rd_lo),
    .cap_d  (cap_byte),
    .q      (hold_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         scr_q <= '0;
    else if (wr_scr) scr_q <= bus_wdata;
  end

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    bridge16_reg #(.DW(16)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .hw_we  (hw_we[k]),
      .hw_d   (hw_data[k*16 +: 16]),
      .commit (wr_hi[k]),
      .hi_d   (bus_wdata),
      .lo_d   (hold_q),
      .q      (reg_q[k*16 +: 16]),
      .load   (reg_load[k])
    );

    // R2
    lo_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_lo[k] && !hw_we[k]) |=> $stable(reg_q[k*16 +: 16]) && !reg_load[k]);

    // R10
    bus_over_hw_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_hi[k] && hw_we[k]) |=> (reg_q[k*16+8 +: 8] == $past(bus_wdata)));
  end

  bridge16_rdmux #(.N_REGS(N_REGS)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .src   (rd_src),
    .idx   (rd_idx),
    .tmp   (hold_q),
    .scr   (scr_q),
    .regs  (reg_q),
    .rdata (bus_rdata)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (bus_rdata == 8'h00 && reg_q == '0 && reg_load == '0));

endmodule

// File: tb/sim_atomic_bridge16.sv
`timescale 1ns/1ps
module sim_atomic_bridge16;

  localparam int N_REGS = 2;
  localparam int ADDR_W = 4;
  localparam int DW     = 16 * N_REGS;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr, bus_rd;
  logic [7:0]        bus_wdata, bus_rdata;
  logic [N_REGS-1:0] hw_we;
  logic [DW-1:0]     hw_data;
  logic [DW-1:0]     reg_q;
  logic [N_REGS-1:0] reg_load;

  int n_chk = 0;
  int n_bad = 0;
  bit cnt_run = 1'b0;

  always #10 clk = ~clk;

  atomic_bridge16 #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_we(hw_we), .hw_data(hw_data),
    .reg_q(reg_q), .reg_load(reg_load)
  );

  // vector: {is_write, addr[3:0], byte[7:0]}; for reads the byte is the expected data
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 4'd2, 8'h34}, {1'b1, 4'd3, 8'h12},   // R3 pair write reg0
    {1'b0, 4'd2, 8'h34}, {1'b0, 4'd3, 8'h12},   // R4 R5 pair read
    {1'b1, 4'd0, 8'hAB}, {1'b0, 4'd0, 8'hAB},   // R6 holding byte
    {1'b1, 4'd1, 8'h5A}, {1'b0, 4'd1, 8'h5A},   // R6 scratch
    {1'b1, 4'd4, 8'hCD}, {1'b1, 4'd5, 8'hEF},   // R3 pair write reg1
    {1'b0, 4'd4, 8'hCD}, {1'b0, 4'd5, 8'hEF},   // R4 R5
    {1'b0, 4'd7, 8'h00}, {1'b0, 4'd6, 8'h00}    // R12 unmapped
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // counter source for the tearing test
  initial begin
    forever begin
      @(negedge clk);
      if (cnt_run) hw_data[15:0] <= hw_data[15:0] + 16'd1;
    end
  end

  initial begin
    #(20 * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual 0x0000 expected 0x0001");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  rb, lo, hi;
    logic [15:0] snap;
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    hw_we = '0; hw_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reg_q", reg_q[15:0] | reg_q[31:16], 16'h0);
    check("R1 rdata", {8'h0, bus_rdata}, 16'h0);
    check("R1 load", {14'h0, reg_load}, 16'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) bus_write(VEC[i][11:8], VEC[i][7:0]);
      else begin
        bus_read(VEC[i][11:8], rb);
        check($sformatf("R4/R5/R6/R12 vec %0d", i), {8'h0, rb}, {8'h0, VEC[i][7:0]});
      end
    end
    check("R3 reg1 value", reg_q[31:16], 16'hEFCD);

    // R2: low write touches only the holding byte
    bus_write(4'd2, 8'h99);
    check("R2 reg0 unchanged", reg_q[15:0], 16'h1234);
    check("R2 no load", {14'h0, reg_load}, 16'h0);
    bus_read(4'd0, rb);
    check("R2 hold got data", {8'h0, rb}, 16'h0099);

    // R3: commit and one-cycle pulse
    @(negedge clk);
    bus_addr = 4'd3; bus_wdata = 8'h56; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R3 reg0 committed", reg_q[15:0], 16'h5699);
    check("R3 load pulse", {14'h0, reg_load}, 16'h0001);
    @(negedge clk);
    check("R3 load ends", {14'h0, reg_load}, 16'h0);

    // R5 / R11: high read returns frozen byte after live change
    bus_read(4'd2, rb);
    check("R4 low byte", {8'h0, rb}, 16'h0099);
    @(negedge clk);
    hw_we[0] = 1'b1; hw_data[15:0] = 16'hA5A5;
    @(negedge clk);
    hw_we[0] = 1'b0;
    check("R11 hw load", reg_q[15:0], 16'hA5A5);
    bus_read(4'd3, rb);
    check("R5 frozen high", {8'h0, rb}, 16'h0056);

    // R7: interleaved access corrupts the pair
    bus_read(4'd2, rb);
    bus_read(4'd4, rb);
    bus_read(4'd3, rb);
    check("R7 read corrupted", {8'h0, rb}, 16'h00EF);
    bus_write(4'd2, 8'h11);
    bus_write(4'd4, 8'h22);
    bus_write(4'd3, 8'h33);
    check("R7 write corrupted", reg_q[15:0], 16'h3322);

    // R8: simultaneous read and write
    bus_read(4'd1, rb);
    @(negedge clk);
    bus_addr = 4'd0; bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R8 rdata held", {8'h0, bus_rdata}, 16'h005A);
    bus_read(4'd0, rb);
    check("R8 write took", {8'h0, rb}, 16'h0077);

    // R9: rdata changes only at the sampling edge
    @(negedge clk);
    bus_addr = 4'd1; bus_rd = 1'b1;
    #5;
    check("R9 before edge", {8'h0, bus_rdata}, 16'h0077);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R9 after edge", {8'h0, bus_rdata}, 16'h005A);

    // R10: bus commit beats hardware load
    @(negedge clk);
    hw_we[0] = 1'b1; hw_data[15:0] = 16'h5555;
    bus_addr = 4'd3; bus_wdata = 8'h44; bus_wr = 1'b1;
    @(negedge clk);
    hw_we[0] = 1'b0; bus_wr = 1'b0;
    check("R10 bus wins", reg_q[15:0], 16'h4477);

    // R12: unmapped write has no effect
    bus_write(4'd7, 8'hFF);
    bus_read(4'd0, rb);
    check("R12 hold intact", {8'h0, rb}, 16'h0077);
    bus_read(4'd1, rb);
    check("R12 scratch intact", {8'h0, rb}, 16'h005A);
    check("R12 regs intact", reg_q[31:16], 16'hEFCD);

    // R11: tear-free pair against a counter crossing a byte carry
    @(negedge clk);
    hw_data[15:0] <= 16'h00F8; hw_we[0] = 1'b1; cnt_run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #1;
      snap = reg_q[15:0];
      bus_addr = 4'd2; bus_rd = 1'b1;
      @(negedge clk);
      lo = bus_rdata;
      bus_addr = 4'd3;
      @(negedge clk);
      bus_rd = 1'b0;
      hi = bus_rdata;
      check($sformatf("R11 atomic pair %0d", i), {hi, lo}, snap);
    end
    cnt_run = 1'b0; hw_we[0] = 1'b0;

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset regs", reg_q[15:0] | reg_q[31:16], 16'h0);
    check("R1 mid reset rdata", {8'h0, bus_rdata}, 16'h0);
    bus_read(4'd0, rb);
    check("R1 hold cleared", {8'h0, rb}, 16'h0);
    bus_read(4'd1, rb);
    check("R1 scratch cleared", {8'h0, rb}, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule